// File: doc/BRIEF.md
# Byte-Lane Static RAM Behavioural Model

This block is a clocked, synthesizable stand-in for a word-wide static RAM with two byte lanes. A memory controller under test can use it in simulation or on an FPGA. It takes a word address, two chip selects of opposite polarity, an active-low output enable, an active-low write enable and one active-low enable per byte lane. It returns a 16-bit read bus and one drive flag per lane. The drive flags take the place of three-state pins. A lane that is not driving returns zeros on its bits of the read bus.

Writes take effect at the rising clock edge while the write condition holds, and only the enabled lanes change. Reads are combinational from the current address, so a new address is reflected in the same cycle. A standby flag shows when the part is idle: it is deselected, or it is selected with neither lane enabled. The contents are not cleared by reset.

The depth is set by the address-width parameter. A width of 17 gives the full 131072-word array. The default is smaller so the model stays light to elaborate.

Top module: `lane_sram_model`

## Requirements
- R1: When `cs_n_i` is 1 or `cs_i` is 0, the part is deselected. Both drive flags are 0, `standby_o` is 1, and a write attempt leaves the memory unchanged.
- R2: When the part is selected but `lb_n_i` and `ub_n_i` are both 1, `standby_o` is 1, neither lane drives, and no write occurs even with `we_n_i` at 0.
- R3: A read needs the part selected, `we_n_i` at 1 and `oe_n_i` at 0. Lane 0 (bits 7:0, enabled by `lb_n_i`=0) and lane 1 (bits 15:8, enabled by `ub_n_i`=0) each drive their stored byte and raise their own drive flag.
- R4: When the part is selected with `we_n_i` at 1 and `oe_n_i` at 1, no lane drives, even with the byte enables at 0.
- R5: A write needs the part selected, `we_n_i` at 0 and at least one byte enable at 0. At the rising edge it stores `din_i` into the enabled lanes only, whatever the level of `oe_n_i`.
- R6: While the write condition holds, both drive flags are 0.
- R7: A read of an address after a one-lane write returns the merged word: the new byte in the written lane and the old byte in the other lane.
- R8: The read data follows the address combinationally. A change of `addr_i` shows on `dout_o` in the same cycle, with no clock edge in between.
- R9: The bits of a lane whose drive flag is 0 read as zero on `dout_o`.
- R10: `standby_o` is 0 whenever the part is selected and at least one byte enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; gates the checks only, the memory is not cleared |
| addr_i | input | ADDR_W | Word address |
| cs_n_i | input | 1 | Active-low chip select |
| cs_i | input | 1 | Active-high chip select |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| lb_n_i | input | 1 | Active-low enable for bits 7:0 |
| ub_n_i | input | 1 | Active-low enable for bits 15:8 |
| din_i | input | 16 | Write data |
| dout_o | output | 16 | Read data; zero on lanes not driving |
| drive_lo_o | output | 1 | Lane 0 (bits 7:0) is driving |
| drive_hi_o | output | 1 | Lane 1 (bits 15:8) is driving |
| standby_o | output | 1 | Part is deselected or has no lane enabled |

## Verification
The assertions check the pin-level rules on every cycle:
- Deselection and the empty-lane case each force standby with no drive.
- A write never coincides with a drive flag.
- A drive flag needs its byte enable low and output enable low.
- Undriven bits are zero.
- Storage follows its write strobe at the next edge.

Only the bench's scenarios can show what a write did to the contents later on:
- byte merging across separate writes;
- that blocked writes under deselection or with no lane enabled left the data alone;
- that reads follow the address with no edge in between.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = BYTE_W * LANES;

  typedef struct packed {
    logic             selected;
    logic             rd_cycle;
    logic             wr_cycle;
    logic             idle;
    logic [LANES-1:0] lane_on;
  } pin_mode_t;

  function automatic logic [LANES-1:0] lane_mask(input logic lo_n, input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

  function automatic logic chip_selected(input logic sel_n, input logic sel);
    return (~sel_n) & sel;
  endfunction
endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
  import lane_sram_pkg::*;
(
  input  logic      cs_n,
  input  logic      cs,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      lb_n,
  input  logic      ub_n,
  output pin_mode_t mode
);
  logic             sel_w;
  logic [LANES-1:0] on_w;

  always_comb begin
    sel_w         = chip_selected(cs_n, cs);
    on_w          = lane_mask(lb_n, ub_n);
    mode.selected = sel_w;
    mode.lane_on  = on_w;
    mode.wr_cycle = sel_w & ~we_n & (|on_w);
    mode.rd_cycle = sel_w & we_n & ~oe_n & (|on_w);
    mode.idle     = ~sel_w | ~(|on_w);
  end
endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WIDTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              drive
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] cell_w;

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
  end

  always_comb begin
    cell_w = store[addr];
    drive  = rd_en & ~wr_en;
    rdata  = drive ? cell_w : '0;
  end

  // R5: a written byte is stored at the edge and reads back from the same address
  p_bank_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($past(addr) != addr) || (cell_w == $past(wdata)));
  // R9: undriven lane shows zero
  p_bank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> rdata == '0);
endmodule

// File: rtl/lane_sram_model.sv
module lane_sram_model
  import lane_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              cs_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              lb_n_i,
  input  logic              ub_n_i,
  input  logic [15:0]       din_i,
  output logic [15:0]       dout_o,
  output logic              drive_lo_o,
  output logic              drive_hi_o,
  output logic              standby_o
);
  pin_mode_t        mode_w;
  logic [LANES-1:0] lane_wr_w;
  logic [LANES-1:0] lane_rd_w;
  logic [LANES-1:0] lane_drv_w;

  lane_sram_decode u_decode (
    .cs_n (cs_n_i),
    .cs   (cs_i),
    .oe_n (oe_n_i),
    .we_n (we_n_i),
    .lb_n (lb_n_i),
    .ub_n (ub_n_i),
    .mode (mode_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr_w[g] = mode_w.wr_cycle & mode_w.lane_on[g];
    assign lane_rd_w[g] = mode_w.rd_cycle & mode_w.lane_on[g];

    lane_sram_bank #(.ADDR_W(ADDR_W), .WIDTH(BYTE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr_i),
      .wr_en (lane_wr_w[g]),
      .rd_en (lane_rd_w[g]),
      .wdata (din_i[g*BYTE_W +: BYTE_W]),
      .rdata (dout_o[g*BYTE_W +: BYTE_W]),
      .drive (lane_drv_w[g])
    );
  end

  assign drive_lo_o = lane_drv_w[0];
  assign drive_hi_o = lane_drv_w[1];
  assign standby_o  = mode_w.idle;

  // R1: deselected part is idle and silent
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || !cs_i) |-> standby_o && !drive_lo_o && !drive_hi_o && lane_wr_w == '0);
  // R2: no lane enabled means standby and no write
  p_no_lane_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n_i && ub_n_i) |-> standby_o && lane_wr_w == '0 && !drive_lo_o && !drive_hi_o);
  // R3: a driving lane needs its enable, output enable and write disable
  p_drive_rules_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_lo_o |-> !lb_n_i && !oe_n_i && we_n_i);
  p_drive_rules_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_hi_o |-> !ub_n_i && !oe_n_i && we_n_i);
  // R4: output enable high silences both lanes
  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !drive_lo_o && !drive_hi_o);
  // R6: no drive during a write
  p_write_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr_w != '0) |-> !drive_lo_o && !drive_hi_o);
  // R10: selected with an enabled lane is not standby
  p_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && cs_i && !(lb_n_i && ub_n_i)) |-> !standby_o);
endmodule

// File: tb/lane_sram_model_tb_top.sv
module lane_sram_model_tb_top;
  localparam int unsigned AW    = 10;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, cs = 1'b0, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0]   din = '0;
  logic [15:0]   dout;
  logic          drv_lo, drv_hi, stby;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          finished = 1'b0;
  logic [15:0] shadow [DEPTH];

  always #4 clk = ~clk;

  lane_sram_model #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_n_i(cs_n), .cs_i(cs),
    .oe_n_i(oe_n), .we_n_i(we_n), .lb_n_i(lb_n), .ub_n_i(ub_n), .din_i(din),
    .dout_o(dout), .drive_lo_o(drv_lo), .drive_hi_o(drv_hi), .standby_o(stby)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pins(input logic a_csn, input logic a_cs, input logic a_oen,
                      input logic a_wen, input logic a_lbn, input logic a_ubn,
                      input logic [AW-1:0] a_addr, input logic [15:0] a_din);
    @(negedge clk);
    cs_n = a_csn; cs = a_cs; oe_n = a_oen; we_n = a_wen;
    lb_n = a_lbn; ub_n = a_ubn; addr = a_addr; din = a_din;
    #1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic lbn, input logic ubn, input logic oen);
    pins(1'b0, 1'b1, oen, 1'b0, lbn, ubn, a, d);
    check("R6 lo float in write", {31'd0, drv_lo}, 32'd0);
    check("R6 hi float in write", {31'd0, drv_hi}, 32'd0);
    if (!lbn) shadow[a][7:0]  = d[7:0];
    if (!ubn) shadow[a][15:8] = d[15:8];
    @(posedge clk);
  endtask

  task automatic read_word(input string tag, input logic [AW-1:0] a, input logic [15:0] exp);
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0);
    check(tag, {16'd0, dout}, {16'd0, exp});
  endtask

  task automatic t_reset;
    check("R1 standby after reset", {31'd0, stby}, 32'd1);
    check("R1 no drive after reset", {30'd0, drv_hi, drv_lo}, 32'd0);
    check("R9 dout zero idle", {16'd0, dout}, 32'd0);
  endtask

  task automatic t_word_write_read;
    do_write(10'd5, 16'hA5C3, 1'b0, 1'b0, 1'b0);
    read_word("R3 R5 full word, oe low in write", 10'd5, 16'hA5C3);
    check("R3 both lanes drive", {30'd0, drv_hi, drv_lo}, 32'd3);
    check("R10 not standby on read", {31'd0, stby}, 32'd0);
  endtask

  task automatic t_lane_reads;
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd5, 16'h0);
    check("R3 R9 low lane only", {16'd0, dout}, 32'h000000C3);
    check("R3 low flag only", {30'd0, drv_hi, drv_lo}, 32'd1);
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5, 16'h0);
    check("R3 R9 high lane only", {16'd0, dout}, 32'h0000A500);
    check("R3 high flag only", {30'd0, drv_hi, drv_lo}, 32'd2);
  endtask

  task automatic t_merge;
    do_write(10'd5, 16'h1177, 1'b0, 1'b1, 1'b1);
    read_word("R7 merged low write", 10'd5, 16'hA577);
    do_write(10'd5, 16'h3C99, 1'b1, 1'b0, 1'b0);
    read_word("R7 merged high write", 10'd5, 16'h3C77);
  endtask

  task automatic t_oe_high;
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 16'h0);
    check("R4 no drive with oe high", {30'd0, drv_hi, drv_lo}, 32'd0);
    check("R4 R9 dout zero", {16'd0, dout}, 32'd0);
    check("R10 not standby oe high", {31'd0, stby}, 32'd0);
  endtask

  task automatic t_deselect_write;
    pins(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd5, 16'hFFFF);
    check("R1 standby cs_n high", {31'd0, stby}, 32'd1);
    @(posedge clk);
    pins(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd5, 16'hEEEE);
    check("R1 standby cs low", {31'd0, stby}, 32'd1);
    check("R1 no drive cs low", {30'd0, drv_hi, drv_lo}, 32'd0);
    @(posedge clk);
    read_word("R1 write ignored when deselected", 10'd5, 16'h3C77);
  endtask

  task automatic t_no_lane_write;
    pins(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'd5, 16'h0000);
    check("R2 standby no lane", {31'd0, stby}, 32'd1);
    check("R2 no drive no lane", {30'd0, drv_hi, drv_lo}, 32'd0);
    @(posedge clk);
    read_word("R2 write ignored with no lane", 10'd5, 16'h3C77);
  endtask

  task automatic t_comb_addr;
    do_write(10'd6, 16'h0F0F, 1'b0, 1'b0, 1'b1);
    read_word("R8 addr 5 before change", 10'd5, 16'h3C77);
    addr = 10'd6;
    #1;
    check("R8 addr change without edge", {16'd0, dout}, 32'h00000F0F);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = (i == 39) ? AW'(DEPTH - 1) : AW'(i * 26 + 1);
      do_write(a, 16'((i * 16'h0731) ^ 16'h5A00), 1'b0, 1'b0, i[0]);
    end
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = (i == 39) ? AW'(DEPTH - 1) : AW'(i * 26 + 1);
      read_word("R5 sweep readback", a, shadow[a]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_word_write_read();
    t_lane_reads();
    t_merge();
    t_oe_high();
    t_deselect_write();
    t_no_lane_write();
    t_comb_addr();
    t_sweep();
    pins(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule